// File: doc/BRIEF.md
# Cascadable Dual 8-bit Compare Timer

Two 8-bit counter channels, each with a pair of compare registers, a clock-source field, a clear-source field, one compare flag and one waveform pin. Each channel can count one of several prescaled tick inputs. A reserved clock-source code links the two channels. If channel 0 carries that code, the pair runs as one 16-bit counter, with channel 0 as the high byte and channel 1 as the low byte. If channel 1 carries it, channel 1 counts the compare-A events of channel 0.

Software reaches the registers through a simple write/read port. `addr_i[3]` selects the channel and `addr_i[2:0]` selects the register:

| Offset | Register | Fields |
|--------|----------|--------|
| 0 | control | [2:0] clock source, [4:3] clear source |
| 1 | status | [0] flag, [2:1] pin action on A, [4:3] pin action on B |
| 2 | compare A | |
| 3 | compare B | |
| 4 | counter | |

A synchronous level input can clear the counters. Reads return data combinationally.

Top module: `tmr_pair`

## Requirements
- R1: After reset, every register reads 0 and both waveform pins are 0. The register map is the one given above.
- R2: Clock source 1, 2 or 3 advances the counter on each cycle in which tick_i[0], tick_i[1] or tick_i[2] is high. Codes 0, 5, 6 and 7 hold the counter. A software write to the counter takes precedence over a clear and over an increment.
- R3: A compare event fires in the cycle after an increment brings the counter to a compare value. The flag sets at the next edge. With clear source 1 (clear on A) or 2 (clear on B), the counter returns to 0 at that same edge, so the count period is compare+1.
- R4: Each 2-bit pin action encodes 0 = hold, 1 = drive 0, 2 = drive 1 and 3 = toggle. The pin changes at the edge where the flag sets. When A and B fire together, the action of B is applied.
- R5: Writing status with bit 0 = 0 clears the flag only if status was read while the flag was 1 and no status write has come since. A status write without that read leaves the flag set. A hardware set in the same cycle as a clear wins.
- R6: Clock source 4 in channel 0, with a different code in channel 1, forms a 16-bit counter. Channel 1 is the low byte and advances on channel 1's tick selection. Channel 0 is the high byte and advances on the low-byte carry.
- R7: In the 16-bit form, the events, flag and pin of channel 0 use a full 16-bit match against {channel 0 compare, channel 1 compare}. The events, flag and pin of channel 1 use a low-byte match only.
- R8: In the 16-bit form, channel 0's clear source clears all 16 bits. Channel 1's clear source has no effect, so the low byte never clears on its own.
- R9: Clear source 3 clears the counter in any cycle where ext_clr_i is high. In the 16-bit form, a 16-bit compare-A event also still clears the counter under that setting.
- R10: Clock source 4 in channel 1, with a different code in channel 0, makes channel 1 advance once per compare-A event of channel 0. Flags, pins and clears stay per channel.
- R11: Clock source 4 in both channels holds both counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 3 | Prescaled count enables |
| ext_clr_i | input | 1 | External counter clear |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (arms flag clear) |
| addr_i | input | 4 | Channel and register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational |
| wave_o | output | 2 | Waveform pins, bit n from channel n |

## Verification
Take the edge that captures a control write as edge 0, with the tick held high. The counter holds value k after edge k. A compare match reached at edge k shows in the flag, the pin and any clear after edge k+1. In the 16-bit form, the carry moves the high byte at the same edge the low byte wraps. An external clear acts at the edge that samples it. In chain mode, channel 1 advances at the very edge where channel 0's compare-A event clears channel 0. Every check samples at the falling edge that follows the predicted rising edge, and counts edges from the write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CSW = 3;
  localparam logic [CSW-1:0] CS_LINK = 3'b100;

  typedef enum logic [1:0] {CLR_NONE, CLR_ON_A, CLR_ON_B, CLR_EXT} clr_e;
  typedef enum logic [1:0] {PIN_HOLD, PIN_LO, PIN_HI, PIN_TGL} pin_e;

  localparam logic [2:0] RG_CTRL = 3'd0;
  localparam logic [2:0] RG_STAT = 3'd1;
  localparam logic [2:0] RG_CMPA = 3'd2;
  localparam logic [2:0] RG_CMPB = 3'd3;
  localparam logic [2:0] RG_CNT  = 3'd4;
endpackage

// File: rtl/tmr_chan.sv
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_ctrl,
  input  logic           wr_stat,
  input  logic           wr_cmpa,
  input  logic           wr_cmpb,
  input  logic           wr_cnt,
  input  logic           rd_stat,
  input  logic [W-1:0]   wdata,
  input  logic           inc,
  input  logic           clr,
  input  logic           evt_a,
  input  logic           evt_b,
  output logic [W-1:0]   cnt,
  output logic [W-1:0]   cmp_a,
  output logic [W-1:0]   cmp_b,
  output logic [CSW-1:0] cs,
  output clr_e           clrsel,
  output logic           upd,
  output logic           flag,
  output logic           wave,
  output logic [W-1:0]   ctrl_rd,
  output logic [W-1:0]   stat_rd
);
  pin_e pa_q, pb_q, pin_sel;
  logic armed_q, armed_n, flag_n, wave_n, upd_n;
  logic [W-1:0] cnt_n;
  logic flag_clr;

  // next-state logic
  always_comb begin
    cnt_n = cnt;
    if (wr_cnt)   cnt_n = wdata;
    else if (clr) cnt_n = '0;
    else if (inc) cnt_n = cnt + 1'b1;
    upd_n = inc & ~clr & ~wr_cnt;

    flag_clr = wr_stat & armed_q & ~wdata[0];
    flag_n   = (evt_a | evt_b) | (flag & ~flag_clr);
    if (wr_stat)            armed_n = 1'b0;
    else if (rd_stat & flag) armed_n = 1'b1;
    else                     armed_n = armed_q;

    pin_sel = evt_b ? pb_q : (evt_a ? pa_q : PIN_HOLD);
    case (pin_sel)
      PIN_LO:  wave_n = 1'b0;
      PIN_HI:  wave_n = 1'b1;
      PIN_TGL: wave_n = ~wave;
      default: wave_n = wave;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; cmp_a <= '0; cmp_b <= '0; cs <= '0; clrsel <= CLR_NONE;
      pa_q <= PIN_HOLD; pb_q <= PIN_HOLD; upd <= 1'b0;
      flag <= 1'b0; armed_q <= 1'b0; wave <= 1'b0;
    end else begin
      cnt     <= cnt_n;
      upd     <= upd_n;
      flag    <= flag_n;
      armed_q <= armed_n;
      wave    <= wave_n;
      if (wr_cmpa) cmp_a <= wdata;
      if (wr_cmpb) cmp_b <= wdata;
      if (wr_ctrl) begin
        cs     <= wdata[CSW-1:0];
        clrsel <= clr_e'(wdata[4:3]);
      end
      if (wr_stat) begin
        pa_q <= pin_e'(wdata[2:1]);
        pb_q <= pin_e'(wdata[4:3]);
      end
    end
  end

  assign ctrl_rd = W'({clrsel, cs});
  assign stat_rd = W'({pb_q, pa_q, flag});

  // R3: a clear without a software write leaves the counter at zero
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr_cnt) |=> (cnt == '0));
  // R5: a hardware set wins over a software clear
  a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_a || evt_b) |=> flag);
  // R5: the flag only falls through an armed status write
  a_r5_armed_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(wr_stat && armed_q));
  // R4: the pin moves only on a compare event
  a_r4_pin_on_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_a || evt_b) |=> $stable(wave));
endmodule

// File: rtl/tmr_link.sv
module tmr_link
  import tmr_pkg::*;
#(
  parameter int W  = 8,
  parameter int NT = 3
) (
  input  logic [CSW-1:0] cs0,
  input  logic [CSW-1:0] cs1,
  input  clr_e           clrsel0,
  input  clr_e           clrsel1,
  input  logic [W-1:0]   cnt0,
  input  logic [W-1:0]   cnt1,
  input  logic [W-1:0]   cmpa0,
  input  logic [W-1:0]   cmpa1,
  input  logic [W-1:0]   cmpb0,
  input  logic [W-1:0]   cmpb1,
  input  logic           upd0,
  input  logic           upd1,
  input  logic [NT-1:0]  tick,
  input  logic           ext_clr,
  output logic           mode16,
  output logic           inc0,
  output logic           inc1,
  output logic           clr0,
  output logic           clr1,
  output logic           eva0,
  output logic           evb0,
  output logic           eva1,
  output logic           evb1
);
  logic t0, t1, chain;

  function automatic logic clr_hit(clr_e s, logic a, logic b, logic x);
    return (s == CLR_ON_A && a) || (s == CLR_ON_B && b) || (s == CLR_EXT && x);
  endfunction

  always_comb begin
    t0 = 1'b0;
    t1 = 1'b0;
    for (int i = 0; i < NT; i++) begin
      if (cs0 == CSW'(i + 1)) t0 = tick[i];
      if (cs1 == CSW'(i + 1)) t1 = tick[i];
    end
    mode16 = (cs0 == CS_LINK) && (cs1 != CS_LINK);
    chain  = (cs1 == CS_LINK) && (cs0 != CS_LINK);

    eva1 = upd1 && (cnt1 == cmpa1);
    evb1 = upd1 && (cnt1 == cmpb1);
    if (mode16) begin
      eva0 = upd1 && ({cnt0, cnt1} == {cmpa0, cmpa1});
      evb0 = upd1 && ({cnt0, cnt1} == {cmpb0, cmpb1});
    end else begin
      eva0 = upd0 && (cnt0 == cmpa0);
      evb0 = upd0 && (cnt0 == cmpb0);
    end

    clr0 = clr_hit(clrsel0, eva0, evb0, ext_clr)
         || (mode16 && clrsel0 == CLR_EXT && eva0);
    clr1 = mode16 ? clr0 : clr_hit(clrsel1, eva1, evb1, ext_clr);

    inc1 = chain ? eva0 : t1;
    inc0 = mode16 ? (t1 && cnt1 == '1) : t0;
  end
endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pkg::*;
#(
  parameter int W  = 8,
  parameter int NT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NT-1:0] tick_i,
  input  logic          ext_clr_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [3:0]    addr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic [1:0]    wave_o
);
  localparam int NCH = 2;

  logic [1:0] rst_pipe;
  logic       rst_s;

  logic [W-1:0]   cnt [NCH], cmpa [NCH], cmpb [NCH], ctrl_rd [NCH], stat_rd [NCH];
  logic [CSW-1:0] cs [NCH];
  clr_e           clrsel [NCH];
  logic [NCH-1:0] inc, clr, eva, evb, upd, flag;
  logic           mode16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic sel;
    assign sel = wr_en_i && (addr_i[3] == ch[0]);
    tmr_chan #(.W(W)) u_chan (
      .clk(clk), .rst_n(rst_s),
      .wr_ctrl(sel && addr_i[2:0] == RG_CTRL),
      .wr_stat(sel && addr_i[2:0] == RG_STAT),
      .wr_cmpa(sel && addr_i[2:0] == RG_CMPA),
      .wr_cmpb(sel && addr_i[2:0] == RG_CMPB),
      .wr_cnt (sel && addr_i[2:0] == RG_CNT),
      .rd_stat(rd_en_i && addr_i[3] == ch[0] && addr_i[2:0] == RG_STAT),
      .wdata(wdata_i), .inc(inc[ch]), .clr(clr[ch]),
      .evt_a(eva[ch]), .evt_b(evb[ch]),
      .cnt(cnt[ch]), .cmp_a(cmpa[ch]), .cmp_b(cmpb[ch]),
      .cs(cs[ch]), .clrsel(clrsel[ch]), .upd(upd[ch]),
      .flag(flag[ch]), .wave(wave_o[ch]),
      .ctrl_rd(ctrl_rd[ch]), .stat_rd(stat_rd[ch])
    );
  end

  tmr_link #(.W(W), .NT(NT)) u_link (
    .cs0(cs[0]), .cs1(cs[1]), .clrsel0(clrsel[0]), .clrsel1(clrsel[1]),
    .cnt0(cnt[0]), .cnt1(cnt[1]), .cmpa0(cmpa[0]), .cmpa1(cmpa[1]),
    .cmpb0(cmpb[0]), .cmpb1(cmpb[1]), .upd0(upd[0]), .upd1(upd[1]),
    .tick(tick_i), .ext_clr(ext_clr_i), .mode16(mode16),
    .inc0(inc[0]), .inc1(inc[1]), .clr0(clr[0]), .clr1(clr[1]),
    .eva0(eva[0]), .evb0(evb[0]), .eva1(eva[1]), .evb1(evb[1])
  );

  always_comb begin
    case (addr_i[2:0])
      RG_CTRL: rdata_o = ctrl_rd[addr_i[3]];
      RG_STAT: rdata_o = stat_rd[addr_i[3]];
      RG_CMPA: rdata_o = cmpa[addr_i[3]];
      RG_CMPB: rdata_o = cmpb[addr_i[3]];
      RG_CNT:  rdata_o = cnt[addr_i[3]];
      default: rdata_o = '0;
    endcase
  end

  // R6: the low-byte wrap carries into the high byte
  a_r6_carry: assert property (@(posedge clk) disable iff (!rst_s)
    (mode16 && inc[1] && !clr[1] && cnt[1] == '1 && !wr_en_i)
      |=> (cnt[0] == $past(cnt[0]) + 1'b1));
  // R8: in the 16-bit form the low byte never clears apart from the high byte
  a_r8_low_follows: assert property (@(posedge clk) disable iff (!rst_s)
    mode16 |-> (clr[1] == clr[0]));
  // R11: both channels linked keeps both counters still
  a_r11_both_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (cs[0] == CS_LINK && cs[1] == CS_LINK && !wr_en_i)
      |=> ($stable(cnt[0]) && $stable(cnt[1])));
endmodule

// File: tb/tmr_pair_bench.sv
module tmr_pair_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] tick_i;
  logic       ext_clr_i, wr_en_i, rd_en_i;
  logic [3:0] addr_i;
  logic [7:0] wdata_i, rdata_o;
  logic [1:0] wave_o;
  int vecs = 0;
  int errs = 0;

  always #10 clk = ~clk;

  tmr_pair u_tmr_pair (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .ext_clr_i(ext_clr_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .wave_o(wave_o)
  );

  task automatic chk(input string what, input int act, input int exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en_i = 0; rd_en_i = 0; ext_clr_i = 0;
    addr_i = 0; wdata_i = 0; tick_i = 3'b001;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic peek(input logic [3:0] a, output int d);
    addr_i = a;
    #1 d = int'(rdata_o);
  endtask

  task automatic t_reset();
    int d;
    do_reset();
    for (int a = 0; a < 16; a++) begin
      if (a[2:0] <= 3'd4) begin
        peek(4'(a), d);
        chk($sformatf("R1 reg %0h after reset", a), d, 0);
      end
    end
    chk("R1 pins after reset", int'(wave_o), 0);
  endtask

  task automatic t_clock_source();
    int d;
    do_reset();
    wr(4'h0, 8'h02);
    repeat (4) @(negedge clk);
    peek(4'h4, d); chk("R2 idle tick source holds", d, 0);
    wr(4'h0, 8'h01);
    repeat (4) @(negedge clk);
    peek(4'h4, d); chk("R2 counts ticks", d, 4);
  endtask

  task automatic t_match_toggle();
    int d;
    do_reset();
    wr(4'h2, 8'h05);
    wr(4'h1, 8'h06);
    wr(4'h0, 8'h09);
    repeat (5) @(negedge clk);
    peek(4'h4, d); chk("R3 counter at compare", d, 5);
    peek(4'h1, d); chk("R3 flag not yet", d & 1, 0);
    @(negedge clk);
    peek(4'h4, d); chk("R3 clear on match", d, 0);
    peek(4'h1, d); chk("R3 flag set", d & 1, 1);
    chk("R4 toggle first", int'(wave_o[0]), 1);
    repeat (6) @(negedge clk);
    chk("R4 toggle second period", int'(wave_o[0]), 0);
  endtask

  task automatic t_flag_clear();
    int d;
    do_reset();
    wr(4'h2, 8'h02);
    wr(4'h0, 8'h09);
    repeat (4) @(negedge clk);
    wr(4'h0, 8'h08);
    repeat (4) @(negedge clk);
    peek(4'h1, d); chk("R5 flag set before clear", d & 1, 1);
    wr(4'h1, 8'h00);
    peek(4'h1, d); chk("R5 write without read ignored", d & 1, 1);
    rd(4'h1);
    wr(4'h1, 8'h00);
    peek(4'h1, d); chk("R5 armed write clears", d & 1, 0);
  endtask

  task automatic t_priority();
    int d;
    do_reset();
    wr(4'hA, 8'h03);
    wr(4'hB, 8'h03);
    wr(4'h9, 8'h0C);
    wr(4'h8, 8'h01);
    repeat (4) @(negedge clk);
    chk("R4 B wins over A", int'(wave_o[1]), 0);
    peek(4'h9, d); chk("R3 ch1 flag", d & 1, 1);
    wr(4'hB, 8'h80);
    wr(4'hC, 8'h00);
    repeat (4) @(negedge clk);
    chk("R4 A alone drives 1", int'(wave_o[1]), 1);
  endtask

  task automatic t_sixteen();
    int d;
    do_reset();
    wr(4'h2, 8'h01);
    wr(4'hA, 8'h02);
    wr(4'h1, 8'h06);
    wr(4'h9, 8'h06);
    wr(4'h0, 8'h0C);
    wr(4'h8, 8'h09);
    repeat (3) @(negedge clk);
    peek(4'hC, d); chk("R8 low byte not cleared by own setting", d, 3);
    peek(4'h4, d); chk("R6 high byte still 0", d, 0);
    peek(4'h9, d); chk("R7 low flag on low match", d & 1, 1);
    peek(4'h1, d); chk("R7 high flag not on low match", d & 1, 0);
    chk("R7 low pin toggled", int'(wave_o[1]), 1);
    repeat (255) @(negedge clk);
    peek(4'h4, d); chk("R6 carry into high byte", d, 1);
    peek(4'hC, d); chk("R6 low byte at 0x02", d, 2);
    @(negedge clk);
    peek(4'h4, d); chk("R8 16-bit clear high", d, 0);
    peek(4'hC, d); chk("R8 16-bit clear low", d, 0);
    peek(4'h1, d); chk("R7 full-match flag", d & 1, 1);
    chk("R7 pins after full match", int'(wave_o), 1);
  endtask

  task automatic t_ext_clear();
    int d;
    do_reset();
    wr(4'h2, 8'h00);
    wr(4'hA, 8'h05);
    wr(4'h0, 8'h1C);
    wr(4'h8, 8'h01);
    repeat (3) @(negedge clk);
    ext_clr_i = 1'b1;
    @(negedge clk);
    ext_clr_i = 1'b0;
    peek(4'hC, d); chk("R9 external clear", d, 0);
    repeat (5) @(negedge clk);
    peek(4'hC, d); chk("R9 counting after external clear", d, 5);
    @(negedge clk);
    peek(4'hC, d); chk("R9 match still clears", d, 0);
    peek(4'h1, d); chk("R9 full-match flag", d & 1, 1);
  endtask

  task automatic t_chain();
    int d;
    do_reset();
    wr(4'hA, 8'h02);
    wr(4'h8, 8'h04);
    wr(4'h2, 8'h02);
    wr(4'h0, 8'h09);
    repeat (3) @(negedge clk);
    peek(4'hC, d); chk("R10 first event counted", d, 1);
    repeat (3) @(negedge clk);
    peek(4'hC, d); chk("R10 second event counted", d, 2);
    peek(4'h9, d); chk("R10 ch1 flag not yet", d & 1, 0);
    @(negedge clk);
    peek(4'h9, d); chk("R10 ch1 own match flag", d & 1, 1);
    repeat (2) @(negedge clk);
    peek(4'hC, d); chk("R10 third event counted", d, 3);
  endtask

  task automatic t_both_linked();
    int d;
    do_reset();
    wr(4'hC, 8'h07);
    wr(4'h8, 8'h04);
    wr(4'h0, 8'h04);
    repeat (10) @(negedge clk);
    peek(4'hC, d); chk("R11 low counter held", d, 7);
    peek(4'h4, d); chk("R11 high counter held", d, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    t_reset();
    t_clock_source();
    t_match_toggle();
    t_flag_clear();
    t_priority();
    t_sixteen();
    t_ext_clear();
    t_chain();
    t_both_linked();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule